// File: doc/BRIEF.md
# Interlocked Strobe/Ready Parallel Port Engine

This block moves bytes across an 8-bit parallel port using a two-wire, four-edge interlocked handshake. The direction is programmable. One wire is an active-low strobe that marks a byte as present. The other is an active-high go line. The go line acts as the acknowledge and also as the flow control. On the core side there is one valid/ready byte stream for each direction.

In receive mode (`dir_out` low), a sender drives the byte and pulls the strobe low. The engine captures the byte and pulls go low as the acknowledge. It raises go again only after two things have happened: the core has taken the byte, and the sender has released the strobe. In transmit mode (`dir_out` high), the engine places the core's byte on the port and then lowers the strobe. It raises the strobe once the receiver pulls go low. It does not start another byte until go is high again.

Both incoming handshake lines pass through a synchroniser before any edge is detected. Software changes the direction only while no transfer is in flight.

Top module: `hs_port_unit`

## Requirements
- R1: After reset, `go_o` is 1, `stb_n_o` is 1 and `rx_valid` is 0. In receive mode `tx_ready` is 0.
- R2: In receive mode, a falling `stb_n_i` captures `pin_data_i` into `rx_data`. `rx_valid` goes to 1 and `go_o` goes to 0 at the third rising clock edge after the strobe falls, and not before.
- R3: In receive mode, `go_o` falls only together with a captured byte, and it stays 0 while `rx_valid` is 1.
- R4: `go_o` returns to 1 only after the byte is taken (`rx_valid` and `rx_ready` both 1 at an edge) and `stb_n_i` is high. If the strobe rises last, `go_o` rises 3 edges after the strobe rises. If the take comes last, `go_o` rises 2 edges after the take.
- R5: In transmit mode, a byte is accepted when `tx_valid` and `tx_ready` are both 1 at an edge. The byte appears on `pin_data_o` at that edge, with `stb_n_o` still 1. `stb_n_o` falls one edge later.
- R6: While `stb_n_o` is 0, `pin_data_o` holds the accepted byte, whatever `tx_data` does.
- R7: In transmit mode, `stb_n_o` returns to 1 at the third edge after `go_i` falls. It falls again only if go was seen high when the byte was accepted.
- R8: `tx_ready` is 0 while the strobe is low and while go is low. It returns to 1 at the third edge after `go_i` rises.
- R9: `pin_oe` equals `dir_out`. In transmit mode, `stb_n_i` is ignored: `rx_valid` stays 0 and `go_o` stays 1. In receive mode, `tx_valid` is ignored: `stb_n_o` stays 1 and `tx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 selects transmit mode, 0 selects receive mode |
| pin_data_i | input | DATA_W | Port data from the pads |
| pin_data_o | output | DATA_W | Port data to the pads |
| pin_oe | output | 1 | Pad output enable |
| stb_n_i | input | 1 | Incoming active-low byte strobe (receive mode) |
| stb_n_o | output | 1 | Outgoing active-low byte strobe (transmit mode) |
| go_i | input | 1 | Incoming go/acknowledge line (transmit mode) |
| go_o | output | 1 | Outgoing go/acknowledge line (receive mode) |
| rx_data | output | DATA_W | Captured byte to the core |
| rx_valid | output | 1 | Captured byte pending |
| rx_ready | input | 1 | Core takes the pending byte |
| tx_data | input | DATA_W | Byte from the core |
| tx_valid | input | 1 | Core offers a byte |
| tx_ready | output | 1 | Engine accepts the offered byte |

## Verification
Every pin input passes through the two-stage synchroniser and one state register, so any reaction to `stb_n_i` or `go_i` is due at the third rising edge after the change. A reaction to a core-side input is due at the first or second edge. The bench drives all inputs on falling edges and moves forward a counted number of falling edges. At each point it checks that the output still holds its old value one edge before the due edge, and has its new value at the due edge. Byte values and the order of take versus strobe release are swept over 32 transfers in each direction.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   typedef enum logic {
      RX_IDLE,
      RX_HOLD
   } rx_st_t;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_SETUP,
      TX_WAIT,
      TX_REL
   } tx_st_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int        WIDTH     = 1,
   parameter int        STAGES    = 2,
   parameter logic      RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hsp_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= {WIDTH{RESET_VAL}};
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsp_rx_engine.sv
module hsp_rx_engine
   import hsp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          stb_s,
   input  logic [DW-1:0] pin_data,
   output logic [DW-1:0] rx_data,
   output logic          rx_valid,
   input  logic          rx_ready,
   output logic          go
);
   rx_st_t state;
   logic   stb_q;
   logic   fall;

   assign fall = stb_q & ~stb_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         go       <= 1'b1;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         stb_q    <= 1'b1;
      end else begin
         stb_q <= stb_s;
         if (!en) begin
            state    <= RX_IDLE;
            go       <= 1'b1;
            rx_valid <= 1'b0;
         end else begin
            case (state)
               RX_IDLE: if (fall) begin
                  rx_data  <= pin_data;
                  rx_valid <= 1'b1;
                  go       <= 1'b0;
                  state    <= RX_HOLD;
               end
               RX_HOLD: begin
                  if (rx_valid && rx_ready)
                     rx_valid <= 1'b0;
                  if (!rx_valid && stb_s) begin
                     go    <= 1'b1;
                     state <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/hsp_tx_engine.sv
module hsp_tx_engine
   import hsp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          go_s,
   input  logic [DW-1:0] tx_data,
   input  logic          tx_valid,
   output logic          tx_ready,
   output logic [DW-1:0] pin_data,
   output logic          stb_n
);
   tx_st_t state;

   assign tx_ready = en && (state == TX_IDLE) && go_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TX_IDLE;
         stb_n    <= 1'b1;
         pin_data <= '0;
      end else if (!en) begin
         state <= TX_IDLE;
         stb_n <= 1'b1;
      end else begin
         case (state)
            TX_IDLE: if (tx_valid && tx_ready) begin
               pin_data <= tx_data;
               state    <= TX_SETUP;
            end
            TX_SETUP: begin
               stb_n <= 1'b0;
               state <= TX_WAIT;
            end
            TX_WAIT: if (!go_s) begin
               stb_n <= 1'b1;
               state <= TX_REL;
            end
            TX_REL: if (go_s) state <= TX_IDLE;
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hs_port_unit.sv
module hs_port_unit #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_out,
   input  logic [DATA_W-1:0] pin_data_i,
   output logic [DATA_W-1:0] pin_data_o,
   output logic              pin_oe,
   input  logic              stb_n_i,
   output logic              stb_n_o,
   input  logic              go_i,
   output logic              go_o,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready
);
   if (DATA_W < 1) begin : g_bad_dw
      $error("hs_port_unit: DATA_W must be at least 1");
   end

   localparam int NLINES = 2;

   logic [NLINES-1:0] line_raw;
   logic [NLINES-1:0] line_sync;
   logic              stb_sync;
   logic              go_sync;

   assign line_raw = {go_i, stb_n_i};
   assign stb_sync = line_sync[0];
   assign go_sync  = line_sync[1];

   hsp_sync #(
      .WIDTH    (NLINES),
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_raw),
      .q    (line_sync)
   );

   hsp_rx_engine #(.DW(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (!dir_out),
      .stb_s   (stb_sync),
      .pin_data(pin_data_i),
      .rx_data (rx_data),
      .rx_valid(rx_valid),
      .rx_ready(rx_ready),
      .go      (go_o)
   );

   hsp_tx_engine #(.DW(DATA_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (dir_out),
      .go_s    (go_sync),
      .tx_data (tx_data),
      .tx_valid(tx_valid),
      .tx_ready(tx_ready),
      .pin_data(pin_data_o),
      .stb_n   (stb_n_o)
   );

   assign pin_oe = dir_out;
endmodule

// File: rtl/hs_port_checker.sv
module hs_port_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_out,
   input logic              stb_n_o,
   input logic              go_o,
   input logic              go_sync,
   input logic              rx_valid,
   input logic              tx_ready,
   input logic [DATA_W-1:0] pin_data_o
);
   // R3: acknowledge only accompanies a captured byte
   a_r3_go_falls_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_out && $fell(go_o)) |-> rx_valid);

   // R3/R4: go stays low while the byte is pending
   a_r4_go_low_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_out && rx_valid) |-> !go_o);

   // R6: port data frozen while strobe is low
   a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_out && !stb_n_o) |-> $stable(pin_data_o));

   // R7: strobe released only after go was seen low
   a_r7_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_out && $rose(stb_n_o)) |-> !$past(go_sync));

   // R7: strobe falls only for a byte accepted while go was high
   a_r7_fall_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_out && $fell(stb_n_o)) |-> $past(go_sync, 2));

   // R8: no acceptance while strobe is low
   a_r8_no_accept_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> stb_n_o);
endmodule

bind hs_port_unit hs_port_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/hs_port_unit_bench.sv
module hs_port_unit_bench;
   localparam int CLK_P = 10;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dir_out = 1'b0;
   logic [DW-1:0] pin_data_i = '0;
   logic [DW-1:0] pin_data_o;
   logic          pin_oe;
   logic          stb_n_i = 1'b1;
   logic          stb_n_o;
   logic          go_i = 1'b1;
   logic          go_o;
   logic [DW-1:0] rx_data;
   logic          rx_valid;
   logic          rx_ready = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_P/2) clk = ~clk;

   hs_port_unit #(.DATA_W(DW), .SYNC_STAGES(2)) u_hs_port_unit (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      if (i == 0) return '0;
      if (i == 1) return '1;
      return DW'((i * 73 + 5) & 255);
   endfunction

   task automatic rx_byte(input logic [DW-1:0] b, input bit take_first);
      pin_data_i = b;
      step(1);
      stb_n_i = 1'b0;
      step(2);
      chk(rx_valid == 1'b0, "R2 early valid", rx_valid, 0);
      chk(go_o == 1'b1, "R2 early go", go_o, 1);
      step(1);
      chk(rx_valid == 1'b1, "R2 valid", rx_valid, 1);
      chk(rx_data == b, "R2 data", rx_data, b);
      chk(go_o == 1'b0, "R3 go low", go_o, 0);
      pin_data_i = ~b;
      if (!take_first) begin
         stb_n_i = 1'b1;
         step(4);
         chk(go_o == 1'b0, "R4 go waits take", go_o, 0);
         chk(rx_data == b, "R2 data held", rx_data, b);
         rx_ready = 1'b1;
         step(1);
         rx_ready = 1'b0;
         chk(rx_valid == 1'b0, "R4 taken", rx_valid, 0);
         chk(go_o == 1'b0, "R4 go one edge", go_o, 0);
         step(1);
         chk(go_o == 1'b1, "R4 go after take", go_o, 1);
      end else begin
         rx_ready = 1'b1;
         step(1);
         rx_ready = 1'b0;
         chk(rx_valid == 1'b0, "R4 taken", rx_valid, 0);
         step(3);
         chk(go_o == 1'b0, "R4 go waits strobe", go_o, 0);
         stb_n_i = 1'b1;
         step(2);
         chk(go_o == 1'b0, "R4 go two edges", go_o, 0);
         step(1);
         chk(go_o == 1'b1, "R4 go after strobe", go_o, 1);
      end
      step(1);
   endtask

   task automatic tx_byte(input logic [DW-1:0] b);
      tx_data  = b;
      tx_valid = 1'b1;
      chk(tx_ready == 1'b1, "R8 ready idle", tx_ready, 1);
      step(1);
      tx_valid = 1'b0;
      chk(pin_data_o == b, "R5 data", pin_data_o, b);
      chk(stb_n_o == 1'b1, "R5 strobe after data", stb_n_o, 1);
      step(1);
      chk(stb_n_o == 1'b0, "R5 strobe low", stb_n_o, 0);
      tx_data = ~b;
      step(2);
      chk(pin_data_o == b, "R6 data steady", pin_data_o, b);
      chk(tx_ready == 1'b0, "R8 no ready in strobe", tx_ready, 0);
      go_i = 1'b0;
      step(2);
      chk(stb_n_o == 1'b0, "R7 strobe early", stb_n_o, 0);
      step(1);
      chk(stb_n_o == 1'b1, "R7 strobe release", stb_n_o, 1);
      step(2);
      chk(tx_ready == 1'b0, "R8 no ready go low", tx_ready, 0);
      go_i = 1'b1;
      step(2);
      chk(tx_ready == 1'b0, "R8 ready early", tx_ready, 0);
      step(1);
      chk(tx_ready == 1'b1, "R8 ready back", tx_ready, 1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(go_o == 1'b1, "R1 go", go_o, 1);
      chk(stb_n_o == 1'b1, "R1 strobe", stb_n_o, 1);
      chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
      chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
      chk(pin_oe == 1'b0, "R9 oe rx", pin_oe, 0);

      // R9: tx side ignored in receive mode
      tx_data  = 8'h3C;
      tx_valid = 1'b1;
      step(5);
      chk(stb_n_o == 1'b1, "R9 strobe idle rx", stb_n_o, 1);
      chk(tx_ready == 1'b0, "R9 no tx_ready rx", tx_ready, 0);
      tx_valid = 1'b0;

      for (int i = 0; i < 32; i++) rx_byte(pat(i), i[0]);

      dir_out = 1'b1;
      step(1);
      chk(pin_oe == 1'b1, "R9 oe tx", pin_oe, 1);
      // R9: incoming strobe ignored in transmit mode
      stb_n_i = 1'b0;
      step(6);
      chk(rx_valid == 1'b0, "R9 no rx valid", rx_valid, 0);
      chk(go_o == 1'b1, "R9 go idle tx", go_o, 1);
      stb_n_i = 1'b1;
      step(4);

      for (int i = 0; i < 32; i++) tx_byte(pat(31 - i));

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule